// File: doc/BRIEF.md
# Vertical Chroma Four-Tap Interpolator

This block applies a four-tap vertical filter to interleaved chroma bytes delivered as a stream. It produces 16-bit intermediate results for a later weighted-prediction stage. A block is set up by a single start pulse, which captures three things: the width in chroma pairs, the height in output rows and four signed 8-bit taps. Source bytes then arrive in raster order on a valid/ready input, one byte per beat. Each row carries twice as many bytes as the width, because the two chroma components alternate. The first row received is the row above the block, so a block of `ht` output rows takes `ht+3` input rows.

Three line buffers of up to 128 bytes each hold the three most recent rows. Each output sample combines one column of those buffers with the incoming byte: the outer taps are subtracted and the inner taps are added, using coefficient magnitudes. The sum wraps modulo 2^16 and leaves without rounding, shifting or clipping. Results are sent in raster order on a valid/ready output through a single register stage. When that register is full and not being drained, input acceptance stops.

The controller is a four-state machine:
- IDLE moves to STREAM on a start pulse with a positive height and a non-zero width.
- IDLE moves to FINISH on a start pulse with a height of zero or below, or with a zero width.
- STREAM moves to DRAIN when the last input byte is accepted.
- DRAIN moves to FINISH when the last result is accepted.
- FINISH returns to IDLE after one cycle, during which `done` is high.

Top module: `chroma_vfilt`

## Requirements
- R1: While reset is held and in the first cycle after reset, `in_ready`, `out_valid` and `done` are low.
- R2: Taps are indexed 0 to 3 from the oldest row to the newest. Each result equals `-|t0|*s(r-1) + |t1|*s(r) + |t2|*s(r+1) - |t3|*s(r+2)` taken modulo 2^16, where |t| is the magnitude of the signed tap and a tap of -128 has magnitude 128. No rounding, shift or clip is applied.
- R3: A row holds 2*wd bytes. Each result at column x uses only the bytes at column x of four consecutive input rows, and results leave in raster order.
- R4: A block consumes exactly (ht+3)*2*wd input bytes and emits exactly ht*2*wd results. The first result becomes valid in the cycle after input byte number 3*2*wd (counted from 0) is accepted.
- R5: A start pulse with a height of zero or below, or with a zero width, raises `done` in the next cycle. It emits no result and accepts no input byte.
- R6: A start pulse while a block is in progress is ignored.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_data` hold their values into the next cycle.
- R8: `done` is high for exactly one cycle, which is the cycle after the last result is accepted.
- R9: Width, height and taps are captured at the accepted start pulse. Later changes on the configuration inputs do not affect the block in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; captures configuration when idle |
| cfg_wd | input | WD_W | Block width in chroma pairs |
| cfg_ht | input | HT_W | Block height in output rows, signed |
| cfg_tap0 | input | 8 | Signed tap for row r-1 |
| cfg_tap1 | input | 8 | Signed tap for row r |
| cfg_tap2 | input | 8 | Signed tap for row r+1 |
| cfg_tap3 | input | 8 | Signed tap for row r+2 |
| in_valid | input | 1 | Source byte present |
| in_data | input | 8 | Unsigned source byte |
| in_ready | output | 1 | Source byte accepted when high together with in_valid |
| out_valid | output | 1 | Result present |
| out_data | output | 16 | Filtered result, modulo 2^16 |
| out_ready | input | 1 | Downstream takes the result |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
On every cycle, the embedded properties check four things:
- the output holds still and input stops while a result waits (R7);
- no result appears while the first three rows are filling (R4);
- `done` stays one cycle wide and follows the last output handshake (R8);
- the stream stays quiet when idle (R1).

The arithmetic depends on whole rows of history, so the filter values can only be shown by the bench scenarios. These cover random and extreme taps including -128, the 128-byte row and the two-byte row. The same holds for the exact input and output counts, for empty blocks, and for start pulses and configuration changes arriving mid-block.

// File: rtl/chroma_vfilt_pkg.sv
package chroma_vfilt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_DRAIN,
        ST_FINISH
    } vf_state_e;

    // Magnitude of a signed tap as an unsigned byte; -128 maps to 128.
    function automatic logic [7:0] tap_mag(input logic [7:0] tap);
        return tap[7] ? 8'(~tap + 8'd1) : tap;
    endfunction

endpackage

// File: rtl/chroma_vfilt_lines.sv
module chroma_vfilt_lines #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    tap_old,
    output logic [7:0]    tap_mid,
    output logic [7:0]    tap_new
);

    logic [7:0] rd [3];

    // Stage 0 holds the oldest row; each write moves one column up a stage.
    for (genvar g = 0; g < 3; g++) begin : g_stage
        logic [7:0] mem [DEPTH];
        logic [7:0] wr_val;

        if (g == 2) begin : g_top
            assign wr_val = din;
        end else begin : g_lower
            assign wr_val = rd[g+1];
        end

        assign rd[g] = mem[addr];

        always_ff @(posedge clk) begin
            if (wr_en) begin
                mem[addr] <= wr_val;
            end
        end
    end

    assign tap_old = rd[0];
    assign tap_mid = rd[1];
    assign tap_new = rd[2];

endmodule

// File: rtl/chroma_vfilt_mac.sv
module chroma_vfilt_mac (
    input  logic [7:0]  mag0,
    input  logic [7:0]  mag1,
    input  logic [7:0]  mag2,
    input  logic [7:0]  mag3,
    input  logic [7:0]  s0,
    input  logic [7:0]  s1,
    input  logic [7:0]  s2,
    input  logic [7:0]  s3,
    output logic [15:0] acc
);

    logic [15:0] p0, p1, p2, p3;

    always_comb begin
        p0  = {8'd0, s0} * {8'd0, mag0};
        p1  = {8'd0, s1} * {8'd0, mag1};
        p2  = {8'd0, s2} * {8'd0, mag2};
        p3  = {8'd0, s3} * {8'd0, mag3};
        acc = p1 + p2 - p0 - p3;
    end

endmodule

// File: rtl/chroma_vfilt.sv
module chroma_vfilt
    import chroma_vfilt_pkg::*;
#(
    parameter int MAX_ROW_BYTES = 128,
    parameter int WD_W = $clog2(MAX_ROW_BYTES / 2) + 1,
    parameter int HT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [WD_W-1:0]        cfg_wd,
    input  logic signed [HT_W-1:0] cfg_ht,
    input  logic [7:0]             cfg_tap0,
    input  logic [7:0]             cfg_tap1,
    input  logic [7:0]             cfg_tap2,
    input  logic [7:0]             cfg_tap3,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic                   out_valid,
    output logic [15:0]            out_data,
    input  logic                   out_ready,
    output logic                   done
);

    localparam int COL_W = $clog2(MAX_ROW_BYTES);
    localparam int LEN_W = COL_W + 1;
    localparam int ROW_W = HT_W + 1;
    localparam int FILL_ROWS = 3;

    vf_state_e        st, st_nx;
    logic [LEN_W-1:0] row_len;
    logic [ROW_W-1:0] rows_total;
    logic [ROW_W-1:0] row_cnt;
    logic [COL_W-1:0] col;
    logic [7:0]       mag [4];
    logic             accept, last_col, last_row, empty_cfg, primed;
    logic [7:0]       t_old, t_mid, t_new;
    logic [15:0]      mac_out;

    assign accept    = in_valid && in_ready;
    assign last_col  = ({1'b0, col} == row_len - LEN_W'(1));
    assign last_row  = (row_cnt == rows_total - ROW_W'(1));
    assign empty_cfg = (cfg_ht <= 0) || (cfg_wd == '0);
    assign primed    = (row_cnt >= ROW_W'(FILL_ROWS));

    // Next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start) st_nx = empty_cfg ? ST_FINISH : ST_STREAM;
            ST_STREAM: if (accept && last_col && last_row) st_nx = ST_DRAIN;
            ST_DRAIN:  if (out_valid && out_ready) st_nx = ST_FINISH;
            ST_FINISH: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // State-derived outputs
    always_comb begin
        in_ready = (st == ST_STREAM) && (!out_valid || out_ready);
        done     = (st == ST_FINISH);
    end

    // Configuration capture and position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_len    <= '0;
            rows_total <= '0;
            row_cnt    <= '0;
            col        <= '0;
            for (int k = 0; k < 4; k++) mag[k] <= '0;
        end else if (st == ST_IDLE) begin
            if (start) begin
                row_len    <= LEN_W'({cfg_wd, 1'b0});
                rows_total <= ROW_W'(cfg_ht) + ROW_W'(FILL_ROWS);
                row_cnt    <= '0;
                col        <= '0;
                mag[0]     <= tap_mag(cfg_tap0);
                mag[1]     <= tap_mag(cfg_tap1);
                mag[2]     <= tap_mag(cfg_tap2);
                mag[3]     <= tap_mag(cfg_tap3);
            end
        end else if (accept) begin
            if (last_col) begin
                col     <= '0;
                row_cnt <= row_cnt + ROW_W'(1);
            end else begin
                col <= col + COL_W'(1);
            end
        end
    end

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (accept && primed) begin
            out_valid <= 1'b1;
            out_data  <= mac_out;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    chroma_vfilt_lines #(.DEPTH(MAX_ROW_BYTES)) u_lines (
        .clk     (clk),
        .wr_en   (accept),
        .addr    (col),
        .din     (in_data),
        .tap_old (t_old),
        .tap_mid (t_mid),
        .tap_new (t_new)
    );

    chroma_vfilt_mac u_mac (
        .mag0 (mag[0]),
        .mag1 (mag[1]),
        .mag2 (mag[2]),
        .mag3 (mag[3]),
        .s0   (t_old),
        .s1   (t_mid),
        .s2   (t_new),
        .s3   (in_data),
        .acc  (mac_out)
    );

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!in_ready && !out_valid));

    p_no_early_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STREAM && !primed) |-> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !in_ready));

    p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN && out_valid && out_ready) |=> done);

    p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STREAM && start && !accept) |=> (st == ST_STREAM));

endmodule

// File: tb/chroma_vfilt_tb.sv
`timescale 1ns/1ps
module chroma_vfilt_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [6:0]        cfg_wd = '0;
    logic signed [7:0] cfg_ht = '0;
    logic [7:0]        cfg_tap0 = '0, cfg_tap1 = '0, cfg_tap2 = '0, cfg_tap3 = '0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready, out_valid, done;
    logic [15:0]       out_data;
    logic              out_ready = 1'b0;

    int total = 0;
    int bad = 0;
    logic [7:0] src [0:10][0:127];

    always #2 clk = ~clk;

    chroma_vfilt u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_wd(cfg_wd), .cfg_ht(cfg_ht),
        .cfg_tap0(cfg_tap0), .cfg_tap1(cfg_tap1), .cfg_tap2(cfg_tap2), .cfg_tap3(cfg_tap3),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mag(input int c);
        return (c < 0) ? -c : c;
    endfunction

    function automatic logic [15:0] model(input int t0, input int t1, input int t2, input int t3,
                                          input int a, input int b, input int c, input int d);
        int s;
        s = -mag(t0) * a + mag(t1) * b + mag(t2) * c - mag(t3) * d;
        return 16'(s);
    endfunction

    task automatic run_block(input int wd, input int ht, input int t0, input int t1,
                             input int t2, input int t3, input bit disturb);
        int rl, n_in, n_out, ii, oi, cyc, last_out;
        bit done_seen, prev_stall, first_seen;
        logic [15:0] prev_data, expv;
        rl = 2 * wd;
        n_in = (ht + 3) * rl;
        n_out = ht * rl;
        for (int r = 0; r < ht + 3; r++)
            for (int c = 0; c < rl; c++) src[r][c] = 8'($urandom);
        @(negedge clk);
        start = 1'b1; cfg_wd = 7'(wd); cfg_ht = 8'(ht);
        cfg_tap0 = 8'(t0); cfg_tap1 = 8'(t1); cfg_tap2 = 8'(t2); cfg_tap3 = 8'(t3);
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R9: configuration inputs change after capture
            cfg_wd = 7'd3; cfg_ht = 8'sd4;
            cfg_tap0 = 8'd9; cfg_tap1 = 8'd1; cfg_tap2 = 8'd200; cfg_tap3 = 8'd77;
        end
        ii = 0; oi = 0; cyc = 0; last_out = -10;
        done_seen = 0; prev_stall = 0; first_seen = 0; prev_data = '0;
        while (!done_seen && cyc < 20000) begin
            in_valid  = (ii < n_in) && ($urandom % 4 != 0);
            in_data   = (ii < n_in) ? src[ii / rl][ii % rl] : 8'h00;
            out_ready = ($urandom % 3 != 0);
            start     = disturb && (cyc == 5 || cyc == 40);
            if (start) cfg_ht = 8'sd0;
            #1;
            if (prev_stall)
                check(out_valid && out_data == prev_data, "R7 held result", int'(out_data), int'(prev_data));
            if (out_valid && !out_ready)
                check(!in_ready, "R7 input stalled", int'(in_ready), 0);
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (done) begin
                done_seen = 1;
                check(oi == n_out && last_out == cyc - 1, "R8 done timing", cyc - last_out, 1);
            end
            if (out_valid && !first_seen) begin
                first_seen = 1;
                check(ii == 3 * rl + 1, "R4 first result position", ii, 3 * rl + 1);
            end
            if (out_valid && out_ready) begin
                if (oi < n_out) begin
                    expv = model(t0, t1, t2, t3, int'(src[oi / rl][oi % rl]),
                                 int'(src[oi / rl + 1][oi % rl]), int'(src[oi / rl + 2][oi % rl]),
                                 int'(src[oi / rl + 3][oi % rl]));
                    check(out_data == expv, "R2 R3 R9 result value", int'(out_data), int'(expv));
                end
                oi++;
                last_out = cyc;
            end
            if (in_valid && in_ready) ii++;
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0; start = 1'b0; out_ready = 1'b0;
        check(done_seen, "R8 done seen", int'(done_seen), 1);
        check(ii == n_in, "R4 bytes consumed", ii, n_in);
        check(oi == n_out, "R4 results emitted", oi, n_out);
        if (disturb) check(oi == n_out, "R6 busy start ignored", oi, n_out);
    endtask

    task automatic run_empty(input int ht, input int wd);
        @(negedge clk);
        start = 1'b1; cfg_ht = 8'(ht); cfg_wd = 7'(wd);
        in_valid = 1'b1; out_ready = 1'b1; in_data = 8'hA5;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(done == 1'b1, "R5 empty block done", int'(done), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            check(!out_valid && !in_ready && !done, "R5 empty block quiet",
                  int'({out_valid, in_ready, done}), 0);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (4) @(negedge clk);
        #1;
        check(!in_ready && !out_valid && !done, "R1 in reset", int'({in_ready, out_valid, done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!in_ready && !out_valid && !done, "R1 after reset", int'({in_ready, out_valid, done}), 0);

        run_block(1, 2, -3, 27, 41, -6, 0);            // R3 narrowest row
        run_block(64, 2, -128, 127, 127, -128, 0);     // R2 extreme taps, R3 full row
        run_empty(0, 4);                               // R5 zero height
        run_empty(-2, 4);                              // R5 negative height
        run_block(4, 4, -4, 54, 16, -2, 1);            // R6 R9 mid-block disturbance
        run_block(2, 2, 0, 0, 0, 0, 0);                // R2 all-zero taps
        for (int n = 0; n < 10; n++) begin
            run_block(1 + int'($urandom % 16), 2 * (1 + int'($urandom % 4)),
                      int'($urandom % 256) - 128, int'($urandom % 256) - 128,
                      int'($urandom % 256) - 128, int'($urandom % 256) - 128, 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule